// File: doc/BRIEF.md
# Memory Access Permission Checker

This block screens a single memory access and decides whether it is allowed. It takes the access address, its kind (data read, data write or instruction fetch), an alignment mask that gives the access width, and a profile select. It returns a corrected address and at most one exception flag. The three active profiles differ in three ways: which address windows are reserved, whether a misaligned access is reported or quietly rounded down, and which exception class a given window raises. The fourth profile code turns every check off.

The check is combinational. A parameter adds a register stage on the outputs. With the default setting the verdict appears one clock after the inputs. A pipeline places the block between address generation and the memory request, and routes the flag to its exception logic.

Top module: `mem_perm_check`

## Requirements
- R1: With `REG_OUT=1`, `addr_o` and `flg_o` show the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low both outputs are zero.
- R2: Flag bits are: 0 misaligned, 1 data access error, 2 data access exception, 3 data store error, 4 instruction access error, 5 instruction access exception. At most one bit is set. When several conditions match, misaligned wins over any error, and any error wins over any exception.
- R3: Profile code 3, or kind code 3, passes `addr_i` through unchanged with no flag. Kind codes: 0 data read, 1 data write, 2 instruction fetch.
- R4: Profile 0, data access with mask 7 inside 0xFE800000–0xFEFFFFFF: a read raises bit 1 and a write raises bit 3. Any other mask in that window raises nothing.
- R5: Profile 0, misaligned data access (`addr_i[3:0] & mask_i` nonzero): the output address has its masked low bits cleared. Bit 1 is raised only when `mis_mask_i` is 0, and it then takes precedence over the store error of R4. When `mis_mask_i` is 1, the window check of R4 is applied to the corrected address.
- R6: Profile 0 fetch: a misaligned fetch is rounded down and raises bit 4. An aligned fetch inside 0xFE800000–0xFEFFFFFF also raises bit 4.
- R7: Profile 1, misaligned data access or fetch: raises bit 0 and outputs the address with its masked low bits cleared. All window checks of R8–R10 use that corrected address.
- R8: Profile 1 data, 0xFEFF0600–0xFEFF7FFF or 0xFE800000–0xFEFEFFFF: a read raises bit 1 and a write raises bit 3.
- R9: Profile 1 data, 0xFE000000–0xFE7FFFFF: raises bit 2.
- R10: Profile 1 fetch: the R8 windows raise bit 4. 0xFE004000–0xFE7FFFFF raises bit 5. 0xFE000000–0xFE003FFF raises bit 5 only when `res_en_i` is 0.
- R11: Profile 2 data performs no alignment and the address passes unchanged. 0xFE800000–0xFEFEFFFF, or 0xFEFF0000–0xFEFFFFFF with mask above 3, raises bit 1 for a read and bit 3 for a write.
- R12: Profile 2 data, 0xFE000000–0xFE3FFFFF or 0xFE408000–0xFE7FFFFF: raises bit 2. 0xFE400000–0xFE407FFF raises bit 2 only when `res_en_i` is 0.
- R13: Profile 2 fetch: the address is always rounded down with no flag. Then 0xFE800000–0xFEFFFFFF raises bit 4, 0xFE008000–0xFE7FFFFF raises bit 5, and 0xFE000000–0xFE007FFF raises bit 5 only when `res_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 32 | Access address |
| kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 no check |
| mask_i | input | 4 | Alignment mask: 0, 1, 3, 7 or 15 |
| prof_i | input | 2 | Profile select, 3 disables checks |
| mis_mask_i | input | 1 | Suppresses the profile 0 misalignment error |
| res_en_i | input | 1 | Opens the gated low windows |
| addr_o | output | 32 | Corrected address |
| flg_o | output | 6 | Exception flag, at most one bit set |

## Verification
The assertions check on every cycle the properties that hold for all inputs: the flag vector has at most one bit set, bypass codes leave the address untouched, profile 1 always reports misalignment, profile 2 data addresses pass unchanged, and fetches never raise a data flag and always leave aligned addresses. The output register is also checked against the combinational result of the cycle before. Which window maps to which flag, the gating by `res_en_i` and `mis_mask_i`, and the exact window edges can only be shown by the bench. It drives directed boundary addresses and random accesses in the reserved area, and compares both outputs against a behavioural model on every clock.

// File: rtl/mem_perm_check.sv
module mem_perm_check #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr_i,
  input  logic [1:0]  kind_i,
  input  logic [3:0]  mask_i,
  input  logic [1:0]  prof_i,
  input  logic        mis_mask_i,
  input  logic        res_en_i,
  output logic [31:0] addr_o,
  output logic [5:0]  flg_o
);
  localparam int FLG_W = 6;
  localparam logic [FLG_W-1:0] F_MIS = 6'h01, F_DERR = 6'h02, F_DEXC = 6'h04,
                               F_SERR = 6'h08, F_IERR = 6'h10, F_IEXC = 6'h20;

  function automatic logic inr(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [31:0] al;
  logic        odd, is_wr, is_fe;
  logic [31:0] c_addr;
  logic [FLG_W-1:0] c_flg;

  assign al    = addr_i & ~{28'h0, mask_i};
  assign odd   = |(addr_i[3:0] & mask_i);
  assign is_wr = (kind_i == 2'd1);
  assign is_fe = (kind_i == 2'd2);

  always_comb begin
    c_addr = addr_i;
    c_flg  = '0;
    if (kind_i != 2'd3) begin
      unique case (prof_i)
        2'd0: begin
          c_addr = al;
          if (is_fe) begin
            if (odd || inr(addr_i, 32'hFE80_0000, 32'hFEFF_FFFF)) c_flg = F_IERR;
          end else if (odd && !mis_mask_i) begin
            c_flg = F_DERR;
          end else if (mask_i == 4'd7 && inr(al, 32'hFE80_0000, 32'hFEFF_FFFF)) begin
            c_flg = is_wr ? F_SERR : F_DERR;
          end
        end
        2'd1: begin
          c_addr = al;
          if (odd) c_flg = F_MIS;
          else if (inr(al, 32'hFEFF_0600, 32'hFEFF_7FFF) || inr(al, 32'hFE80_0000, 32'hFEFE_FFFF))
            c_flg = is_fe ? F_IERR : (is_wr ? F_SERR : F_DERR);
          else if (is_fe) begin
            if (inr(al, 32'hFE00_4000, 32'hFE7F_FFFF) ||
                (!res_en_i && inr(al, 32'hFE00_0000, 32'hFE00_3FFF))) c_flg = F_IEXC;
          end else if (inr(al, 32'hFE00_0000, 32'hFE7F_FFFF)) c_flg = F_DEXC;
        end
        2'd2: begin
          if (is_fe) begin
            c_addr = al;
            if (inr(al, 32'hFE80_0000, 32'hFEFF_FFFF)) c_flg = F_IERR;
            else if (inr(al, 32'hFE00_8000, 32'hFE7F_FFFF) ||
                     (!res_en_i && inr(al, 32'hFE00_0000, 32'hFE00_7FFF))) c_flg = F_IEXC;
          end else if (inr(addr_i, 32'hFE80_0000, 32'hFEFE_FFFF) ||
                       (mask_i > 4'd3 && inr(addr_i, 32'hFEFF_0000, 32'hFEFF_FFFF))) begin
            c_flg = is_wr ? F_SERR : F_DERR;
          end else if (inr(addr_i, 32'hFE00_0000, 32'hFE3F_FFFF) ||
                       inr(addr_i, 32'hFE40_8000, 32'hFE7F_FFFF) ||
                       (!res_en_i && inr(addr_i, 32'hFE40_0000, 32'hFE40_7FFF))) begin
            c_flg = F_DEXC;
          end
        end
        default: ;
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_o <= '0;
          flg_o  <= '0;
        end else begin
          addr_o <= c_addr;
          flg_o  <= c_flg;
        end
      end
      AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (addr_o == $past(c_addr) && flg_o == $past(c_flg))); // R1
    end else begin : g_comb
      assign addr_o = c_addr;
      assign flg_o  = c_flg;
    end
  endgenerate

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_flg)); // R2
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_i == 2'd3 || kind_i == 2'd3) |-> (c_addr == addr_i && c_flg == '0)); // R3
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fe && prof_i != 2'd3) |-> ((c_addr[3:0] & mask_i) == 4'h0)); // R6
  AST_B_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_i == 2'd1 && kind_i != 2'd3 && odd) |-> c_flg == F_MIS); // R7
  AST_FETCH_NO_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    is_fe |-> (c_flg[3:1] == 3'b000)); // R10
  AST_C_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_i == 2'd2 && kind_i[1] == 1'b0) |-> c_addr == addr_i); // R11
endmodule

// File: tb/tb_mem_perm_check.sv
module tb_mem_perm_check;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  kind_i = '0, prof_i = '0;
  logic [3:0]  mask_i = '0;
  logic        mis_mask_i = 1'b0, res_en_i = 1'b0;
  logic [31:0] addr_o;
  logic [5:0]  flg_o;

  mem_perm_check #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .kind_i(kind_i), .mask_i(mask_i),
    .prof_i(prof_i), .mis_mask_i(mis_mask_i), .res_en_i(res_en_i),
    .addr_o(addr_o), .flg_o(flg_o));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [37:0] expq[$];
  string       tagq[$];
  logic [37:0] held = '0;

  function automatic bit w(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [37:0] model(input int v, input int k, input logic [31:0] a,
                                        input logic [3:0] m, input bit mm, input bit re);
    logic [31:0] aa;
    bit odd, wr, fe;
    logic [5:0] f;
    aa = a & ~{28'h0, m};
    odd = (a[3:0] & m) != 4'h0;
    wr = (k == 1);
    fe = (k == 2);
    f = 6'h0;
    if (v == 3 || k == 3) return {a, 6'h0};
    if (v == 0) begin
      if (fe) begin
        if (odd || w(a, 32'hFE800000, 32'hFEFFFFFF)) f = 6'h10;
      end else if (odd && !mm) f = 6'h02;
      else if (m == 4'd7 && w(aa, 32'hFE800000, 32'hFEFFFFFF)) f = wr ? 6'h08 : 6'h02;
      return {aa, f};
    end
    if (v == 1) begin
      if (odd) f = 6'h01;
      else if (w(aa, 32'hFEFF0600, 32'hFEFF7FFF) || w(aa, 32'hFE800000, 32'hFEFEFFFF))
        f = fe ? 6'h10 : (wr ? 6'h08 : 6'h02);
      else if (fe) begin
        if (w(aa, 32'hFE004000, 32'hFE7FFFFF) || (!re && w(aa, 32'hFE000000, 32'hFE003FFF))) f = 6'h20;
      end else if (w(aa, 32'hFE000000, 32'hFE7FFFFF)) f = 6'h04;
      return {aa, f};
    end
    if (fe) begin
      if (w(aa, 32'hFE800000, 32'hFEFFFFFF)) f = 6'h10;
      else if (w(aa, 32'hFE008000, 32'hFE7FFFFF) || (!re && w(aa, 32'hFE000000, 32'hFE007FFF))) f = 6'h20;
      return {aa, f};
    end
    if (w(a, 32'hFE800000, 32'hFEFEFFFF) || (m > 4'd3 && w(a, 32'hFEFF0000, 32'hFEFFFFFF)))
      f = wr ? 6'h08 : 6'h02;
    else if (w(a, 32'hFE000000, 32'hFE3FFFFF) || w(a, 32'hFE408000, 32'hFE7FFFFF) ||
             (!re && w(a, 32'hFE400000, 32'hFE407FFF))) f = 6'h04;
    return {a, f};
  endfunction

  task automatic chk(input string tag, input logic [37:0] act, input logic [37:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got addr=%h flags=%b, want addr=%h flags=%b",
               tag, act[37:6], act[5:0], exp[37:6], exp[5:0]);
    end
  endtask

  task automatic step(input int v, input int k, input logic [31:0] a, input logic [3:0] m,
                      input bit mm, input bit re, input string tag);
    @(negedge clk);
    if (expq.size() > 0) begin
      held = expq.pop_front();
      chk(tagq.pop_front(), {addr_o, flg_o}, held);
    end
    prof_i = v[1:0]; kind_i = k[1:0]; addr_i = a; mask_i = m; mis_mask_i = mm; res_en_i = re;
    expq.push_back(model(v, k, a, m, mm, re));
    tagq.push_back(tag);
    #1;
    chk("R1 hold before edge", {addr_o, flg_o}, held);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: got hung run, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    addr_i = 32'hFE800001; kind_i = 2'd0; mask_i = 4'd7;
    repeat (3) @(negedge clk);
    chk("R1 reset", {addr_o, flg_o}, 38'h0);
    addr_i = '0; mask_i = '0;
    @(negedge clk);
    rst_n = 1'b1;

    step(3, 0, 32'hFE800001, 4'd7, 0, 0, "R3 profile off");
    step(1, 3, 32'hFE000002, 4'd3, 0, 0, "R3 kind off");
    step(0, 0, 32'hFE800000, 4'd7, 0, 1, "R4 read wide");
    step(0, 1, 32'hFE800000, 4'd7, 0, 1, "R4 write wide");
    step(0, 0, 32'hFE7FFFF8, 4'd7, 0, 1, "R4 below window");
    step(0, 0, 32'hFE800000, 4'd3, 0, 1, "R4 narrow mask");
    step(0, 0, 32'hFEFFFFF8, 4'd7, 0, 1, "R4 top edge");
    step(0, 0, 32'h00001002, 4'd3, 0, 1, "R5 misaligned raised");
    step(0, 0, 32'h00001002, 4'd3, 1, 1, "R5 misaligned masked");
    step(0, 1, 32'hFE800004, 4'd7, 0, 1, "R5 precedence over store");
    step(0, 1, 32'hFE800004, 4'd7, 1, 1, "R5 masked then store");
    step(0, 2, 32'h00000102, 4'd3, 0, 1, "R6 fetch misaligned");
    step(0, 2, 32'hFE900000, 4'd3, 0, 1, "R6 fetch window");
    step(0, 2, 32'hFE7FFFFC, 4'd3, 0, 1, "R6 fetch clear");
    step(1, 0, 32'h00000006, 4'd3, 0, 1, "R7 misaligned");
    step(1, 0, 32'hFE800001, 4'd1, 0, 1, "R7 R2 misaligned over error");
    step(1, 0, 32'hFEFF05FF, 4'd1, 0, 1, "R7 corrected");
    step(1, 2, 32'hFE000002, 4'd3, 0, 0, "R7 fetch misaligned");
    step(1, 0, 32'hFEFF0600, 4'd3, 0, 1, "R8 read low edge");
    step(1, 1, 32'hFEFF7FFC, 4'd3, 0, 1, "R8 write");
    step(1, 0, 32'hFEFF8000, 4'd3, 0, 1, "R8 above window");
    step(1, 0, 32'hFEFEFFFC, 4'd3, 0, 1, "R8 second window");
    step(1, 1, 32'hFE800000, 4'd0, 0, 1, "R8 write byte");
    step(1, 0, 32'hFE000000, 4'd3, 0, 1, "R9 low edge");
    step(1, 1, 32'hFE7FFFFC, 4'd3, 0, 1, "R9 high edge");
    step(1, 0, 32'hFDFFFFFC, 4'd3, 0, 0, "R9 below");
    step(1, 2, 32'hFE000000, 4'd3, 0, 0, "R10 gated on");
    step(1, 2, 32'hFE000000, 4'd3, 0, 1, "R10 gated off");
    step(1, 2, 32'hFE004000, 4'd3, 0, 1, "R10 exception");
    step(1, 2, 32'hFEFF0600, 4'd3, 0, 1, "R10 error");
    step(1, 2, 32'hFEFF0000, 4'd3, 0, 1, "R10 gap");
    step(2, 0, 32'hFE800003, 4'd3, 0, 1, "R11 no align error");
    step(2, 1, 32'hFEFF0000, 4'd7, 0, 1, "R11 wide store");
    step(2, 0, 32'hFEFF0000, 4'd3, 0, 1, "R11 word ok");
    step(2, 0, 32'hFEFFFFF0, 4'd15, 0, 1, "R11 quad");
    step(2, 0, 32'h00000003, 4'd3, 0, 1, "R11 unaligned passes");
    step(2, 0, 32'hFE400000, 4'd3, 0, 0, "R12 gated on");
    step(2, 0, 32'hFE400000, 4'd3, 0, 1, "R12 gated off");
    step(2, 1, 32'hFE408000, 4'd3, 0, 1, "R12 upper");
    step(2, 0, 32'hFE3FFFFC, 4'd3, 0, 1, "R12 lower");
    step(2, 0, 32'hFE800000, 4'd3, 0, 0, "R12 R2 error over exception");
    step(2, 2, 32'hFE000006, 4'd3, 0, 0, "R13 gated on");
    step(2, 2, 32'hFE000006, 4'd3, 0, 1, "R13 gated off");
    step(2, 2, 32'hFE008000, 4'd3, 0, 1, "R13 exception");
    step(2, 2, 32'hFEFFFFFC, 4'd3, 0, 1, "R13 error");
    step(2, 2, 32'hFF000000, 4'd3, 0, 1, "R13 clear");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      logic [31:0] a;
      case ($urandom % 5)
        0: m = 4'd0; 1: m = 4'd1; 2: m = 4'd3; 3: m = 4'd7; default: m = 4'd15;
      endcase
      a = ((i % 8) == 0) ? $urandom : (32'hFE000000 | ($urandom & 32'h01FFFFFF));
      step(int'($urandom % 4), int'($urandom % 4), a, m, bit'($urandom % 2), bit'($urandom % 2),
           "R2 random");
    end
    step(3, 3, 32'h0, 4'd0, 0, 0, "R3 drain");
    @(negedge clk);
    while (expq.size() > 0) chk(tagq.pop_front(), {addr_o, flg_o}, expq.pop_front());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule